// File: doc/BRIEF.md
# Byte-Lane Static RAM Emulator

A synthesizable stand-in for an asynchronous 16-bit static RAM with two byte lanes, meant for FPGA test setups where the real part is not fitted. The control pins are all active low: chip select, write strobe, output gate and one enable per byte lane. A fast internal clock samples them. Each lane keeps its own storage, so a write can change the low byte, the high byte or both.

The read path is registered. Instead of a tri-state bus, the block returns a 16-bit read value and a drive flag for each byte lane. The surrounding top level builds the pad bus from these. A write takes effect on the clock edge at which its write condition stops being true. It stores the address and data sampled at the last edge where the write was still active, which models a write that completes on its terminating edge. A registered standby flag reports when the part is deselected. The word count is a parameter. A 64K-word part uses an address width of 16, and the default is kept small so that elaboration stays light.

Top module: `sram_emu`

## Requirements
- R1: With `sel_n`=0, `wr_n`=0 and both lane enables low, the full word is stored. The store happens at the first clock edge where that condition no longer holds, and it uses the address and data sampled at the previous edge, so in a multi-cycle write the last data wins.
- R2: Lane 0 covers data bits 7:0 and is enabled by `lane_n[0]`=0. Lane 1 covers bits 15:8 and is enabled by `lane_n[1]`=0. A write changes only the enabled lanes, and a disabled lane keeps its old contents.
- R3: A read needs `sel_n`=0, `wr_n`=1 and `gate_n`=0. Lane i then raises `rdrive[i]` only if `lane_n[i]`=0, and the matching byte of `rdata` equals the stored byte.
- R4: While `sel_n`=0 and `wr_n`=0, both drive flags are low even if `gate_n`=0.
- R5: If `sel_n`=1 or `gate_n`=1, both drive flags are low. The mode with `sel_n`=0, `wr_n`=1 and `gate_n`=1 writes nothing.
- R6: `standby` is 1 when `sel_n`=1 or when both lane enables are high, and 0 otherwise.
- R7: While `rst_n` is low, both drive flags are 0 and `standby` is 1. No write is pending when reset ends.
- R8: A read whose edge is also the terminating edge of a write to the same address returns the newly written bytes.
- R9: `rdrive`, `rdata` and `standby` reflect the pins sampled at the most recent rising clock edge, which is one register stage.
- R10: A write ended by `sel_n` rising or by a lane enable going high also stores its data, following the R1 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| gate_n | input | 1 | Output gate, active low |
| lane_n | input | 2 | Byte-lane enables, active low; bit 0 covers bits 7:0 |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data from the bus |
| rdata | output | 16 | Registered read value |
| rdrive | output | 2 | Per-lane drive flags for the pad bus |
| standby | output | 1 | Deselected indication |

## Verification
A write commit and a read can fall on the same edge. This happens when a write to address A ends because the write strobe rises while the output gate is already low and the address stays at A. The bench drives exactly this pattern, for full-word and for single-lane writes. It judges the result against a reference array in the bench that is updated before the read is evaluated, so the returned word has to carry the new bytes in the same cycle the read first drives.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
   // operating mode decoded from the control pins
   typedef enum logic [1:0] {
      MODE_IDLE   = 2'd0,
      MODE_READ   = 2'd1,
      MODE_WRITE  = 2'd2,
      MODE_OUTOFF = 2'd3
   } mode_e;

   localparam int LANE_BITS = 8;
endpackage

// File: rtl/sram_emu_dec.sv
module sram_emu_dec
   import sram_emu_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             sel_n,
   input  logic             wr_n,
   input  logic             gate_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             s_sel_n,
   input  logic             s_wr_n,
   input  logic [LANES-1:0] s_lane_n,
   output mode_e            mode,
   output logic [LANES-1:0] commit,
   output logic [LANES-1:0] rd_live,
   output logic             stby_now
);
   logic deselect;
   assign deselect = sel_n | (&lane_n);
   assign stby_now = deselect;

   always_comb begin
      if (deselect)     mode = MODE_IDLE;
      else if (!wr_n)   mode = MODE_WRITE;
      else if (!gate_n) mode = MODE_READ;
      else              mode = MODE_OUTOFF;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic wr_now, wr_held;
      assign wr_now     = !sel_n && !wr_n && !lane_n[i];
      assign wr_held    = !s_sel_n && !s_wr_n && !s_lane_n[i];
      assign commit[i]  = wr_held && !wr_now;
      assign rd_live[i] = (mode == MODE_READ) && !lane_n[i];
   end
endmodule

// File: rtl/sram_emu_lane.sv
module sram_emu_lane #(
   parameter int ADDR_W   = 10,
   parameter int LANE_W   = 8,
   parameter bit READ_FWD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_live,
   output logic [LANE_W-1:0] rd_q,
   output logic              drv_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] cells [DEPTH];
   logic [LANE_W-1:0] rd_next;

   always_ff @(posedge clk) begin
      if (commit) cells[wr_addr] <= wr_data;
   end

   if (READ_FWD) begin : g_fwd
      // a write finishing on this edge is visible to the read on the same edge
      assign rd_next = (commit && (wr_addr == rd_addr)) ? wr_data : cells[rd_addr];
   end else begin : g_plain
      assign rd_next = cells[rd_addr];
   end

   always_ff @(posedge clk) rd_q <= rd_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_q <= 1'b0;
      else        drv_q <= rd_live;
   end
endmodule

// File: rtl/sram_emu.sv
module sram_emu
   import sram_emu_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int LANES    = 2,
   parameter bit READ_FWD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sel_n,
   input  logic                       wr_n,
   input  logic                       gate_n,
   input  logic [LANES-1:0]           lane_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [LANES*LANE_BITS-1:0] wdata,
   output logic [LANES*LANE_BITS-1:0] rdata,
   output logic [LANES-1:0]           rdrive,
   output logic                       standby
);
   localparam int DATA_W = LANES * LANE_BITS;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("sram_emu: ADDR_W out of range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("sram_emu: LANES must be positive");
   end

   // pins sampled at the previous edge
   logic              s_sel_n, s_wr_n;
   logic [LANES-1:0]  s_lane_n;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_sel_n  <= 1'b1;
         s_wr_n   <= 1'b1;
         s_lane_n <= '1;
         s_addr   <= '0;
         s_wdata  <= '0;
      end else begin
         s_sel_n  <= sel_n;
         s_wr_n   <= wr_n;
         s_lane_n <= lane_n;
         s_addr   <= addr;
         s_wdata  <= wdata;
      end
   end

   mode_e            mode;
   logic [LANES-1:0] commit, rd_live;
   logic             stby_now;

   sram_emu_dec #(.LANES(LANES)) u_dec (
      .sel_n    (sel_n),
      .wr_n     (wr_n),
      .gate_n   (gate_n),
      .lane_n   (lane_n),
      .s_sel_n  (s_sel_n),
      .s_wr_n   (s_wr_n),
      .s_lane_n (s_lane_n),
      .mode     (mode),
      .commit   (commit),
      .rd_live  (rd_live),
      .stby_now (stby_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) standby <= 1'b1;
      else        standby <= stby_now;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sram_emu_lane #(
         .ADDR_W   (ADDR_W),
         .LANE_W   (LANE_BITS),
         .READ_FWD (READ_FWD)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .commit  (commit[i]),
         .wr_addr (s_addr),
         .wr_data (s_wdata[i*LANE_BITS +: LANE_BITS]),
         .rd_addr (addr),
         .rd_live (rd_live[i]),
         .rd_q    (rdata[i*LANE_BITS +: LANE_BITS]),
         .drv_q   (rdrive[i])
      );
   end
endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_n,
   input logic             wr_n,
   input logic             gate_n,
   input logic [LANES-1:0] lane_n,
   input logic [LANES-1:0] rdrive,
   input logic             standby
);
   // R4: write in progress silences every lane
   p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !wr_n) |=> (rdrive == '0));

   // R5: deselect or closed gate silences every lane
   p_gate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n || gate_n) |=> (rdrive == '0));

   // R6: standby follows deselect
   p_standby_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n || (&lane_n)) |=> standby);

   p_standby_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !(&lane_n)) |=> !standby);

   // R3: lane drives exactly when read is open on it
   p_lane0_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && wr_n && !gate_n && !lane_n[0]) |=> rdrive[0]);

   p_lane0_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_n[0] |=> !rdrive[0]);

   p_lane1_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_n[LANES-1] |=> !rdrive[LANES-1]);

   // R7: reset state
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_state_r7: assert (rdrive == '0 && standby);
      end
   end
endmodule

bind sram_emu sram_emu_chk #(.LANES(LANES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_n   (sel_n),
   .wr_n    (wr_n),
   .gate_n  (gate_n),
   .lane_n  (lane_n),
   .rdrive  (rdrive),
   .standby (standby)
);

// File: tb/sram_emu_tb_top.sv
module sram_emu_tb_top;
   localparam int AW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1, wr_n = 1'b1, gate_n = 1'b1;
   logic [1:0]  lane_n = 2'b11;
   logic [AW-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  rdrive;
   logic        standby;

   always #10 clk = ~clk;

   sram_emu #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .gate_n(gate_n),
      .lane_n(lane_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdrive(rdrive), .standby(standby)
   );

   typedef struct {
      logic [1:0]  drv;
      logic [15:0] data;
      logic        stby;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0, fails = 0;

   // reference model
   logic [15:0] model [int];
   logic [1:0]  prev_wr = 2'b00;
   logic [AW-1:0] prev_addr = '0;
   logic [15:0] prev_data = '0;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // driver: apply one cycle of pins and queue what the outputs must show
   task automatic step(input string tag, input logic s, input logic w, input logic g,
                       input logic [1:0] ln, input logic [AW-1:0] a, input logic [15:0] d);
      exp_t e;
      logic [1:0] wr_now;
      @(negedge clk);
      sel_n = s; wr_n = w; gate_n = g; lane_n = ln; addr = a; wdata = d;
      for (int l = 0; l < 2; l++) begin
         wr_now[l] = !s && !w && !ln[l];
         if (prev_wr[l] && !wr_now[l]) begin
            logic [15:0] cur;
            cur = model.exists(int'(prev_addr)) ? model[int'(prev_addr)] : 16'h0000;
            cur[l*8 +: 8] = prev_data[l*8 +: 8];
            model[int'(prev_addr)] = cur;
         end
      end
      prev_wr = wr_now; prev_addr = a; prev_data = d;
      for (int l = 0; l < 2; l++) e.drv[l] = !s && w && !g && !ln[l];
      e.data = model.exists(int'(a)) ? model[int'(a)] : 16'h0000;
      e.stby = s | (&ln);
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compare one queued item per clock, away from the edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check({e.tag, " R9 drive"}, {14'd0, rdrive}, {14'd0, e.drv});
         check({e.tag, " R6 standby"}, {15'd0, standby}, {15'd0, e.stby});
         for (int l = 0; l < 2; l++)
            if (e.drv[l]) check({e.tag, " R3 data"}, {8'd0, rdata[l*8 +: 8]}, {8'd0, e.data[l*8 +: 8]});
      end
   end

   task automatic idle(input string tag);
      step(tag, 1'b1, 1'b1, 1'b1, 2'b11, '0, 16'h0);
   endtask

   task automatic rd(input string tag, input logic [1:0] ln, input logic [AW-1:0] a);
      step(tag, 1'b0, 1'b1, 1'b0, ln, a, 16'hDEAD);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R7 reset drive", {14'd0, rdrive}, 16'd0);
      check("R7 reset standby", {15'd0, standby}, 16'd1);
      @(negedge clk); rst_n = 1'b1;
      idle("R7 after reset");

      // R1 full word, multi-cycle write, last data wins
      step("R1 wr", 1'b0, 1'b0, 1'b1, 2'b00, 10'd5, 16'h1111);
      step("R1 wr", 1'b0, 1'b0, 1'b1, 2'b00, 10'd5, 16'hA5A5);
      idle("R1 end");
      rd("R1 read", 2'b00, 10'd5);
      // R2 single lanes
      step("R2 lo", 1'b0, 1'b0, 1'b1, 2'b10, 10'd5, 16'hFF3C);
      idle("R2 end");
      rd("R2 read lo", 2'b00, 10'd5);
      step("R2 hi", 1'b0, 1'b0, 1'b1, 2'b01, 10'd5, 16'h7E00);
      idle("R2 end");
      rd("R2 read hi", 2'b00, 10'd5);
      // R3 lane-selective reads
      rd("R3 lane0", 2'b10, 10'd5);
      rd("R3 lane1", 2'b01, 10'd5);
      // R4 write with gate open, then R8 same-edge read of new data
      step("R4 wr gate", 1'b0, 1'b0, 1'b0, 2'b00, 10'd9, 16'h1234);
      rd("R8 fwd", 2'b00, 10'd9);
      step("R4 wr lane", 1'b0, 1'b0, 1'b0, 2'b01, 10'd9, 16'hAB00);
      rd("R8 fwd lane", 2'b00, 10'd9);
      // R5 deselect, closed gate, output-off writes nothing
      step("R5 desel", 1'b1, 1'b1, 1'b0, 2'b00, 10'd5, 16'h0);
      step("R5 outoff", 1'b0, 1'b1, 1'b1, 2'b00, 10'd5, 16'h9999);
      step("R5 outoff", 1'b0, 1'b1, 1'b1, 2'b00, 10'd5, 16'h8888);
      rd("R5 unchanged", 2'b00, 10'd5);
      // R6 both lanes off: standby, no write
      step("R6 lanes off", 1'b0, 1'b0, 1'b1, 2'b11, 10'd5, 16'h0000);
      idle("R6 end");
      rd("R6 unchanged", 2'b00, 10'd5);
      // R10 ends by select rising and by lane enable rising
      step("R10 wr", 1'b0, 1'b0, 1'b1, 2'b00, 10'd12, 16'hBEEF);
      step("R10 sel end", 1'b1, 1'b0, 1'b1, 2'b00, 10'd12, 16'h0);
      rd("R10 read", 2'b00, 10'd12);
      step("R10 wr", 1'b0, 1'b0, 1'b1, 2'b00, 10'd12, 16'hC0DE);
      step("R10 lane end", 1'b0, 1'b0, 1'b1, 2'b01, 10'd12, 16'h5555);
      idle("R10 end");
      rd("R10 read lanes", 2'b00, 10'd12);
      rd("R3 other addr", 2'b00, 10'd9);
      idle("done");
      @(negedge clk);
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule